// File: doc/BRIEF.md
# Power-Up Bank Recovery Scanner

This block runs once after reset. The nonvolatile store is split into banks, and only one bank holds the live record at a time. Each bank contains two copies of the record, called part 0 and part 1. Each part is a few data bytes followed by a check byte, which is the XOR of those data bytes.

The scanner walks the banks and reads both parts of each one, then checks both check bytes. A bank is usable when at least one part passes its check. It skips banks that are unusable. The first usable bank becomes the active bank. A power cut during an update leaves one part valid and the other corrupt. In that case the scanner copies the valid part over the corrupt one and reads every written byte back to confirm it. When no bank can be used, it asks for maintenance.

The block drives the same single-byte read/write memory port that the update logic uses. It raises a ready flag when it has finished.

Top module: `bank_scan_top`

## Requirements
- R1: During reset and in the first cycle after it, `scan_ready` and `maint_req` are low, and the scanner issues a read of address 0 (bank 0, part 0, byte 0).
- R2: Memory layout: the byte `k` of part `p` in bank `b` sits at address `b*2*(PART_BYTES+1) + p*(PART_BYTES+1) + k`. Byte `k = PART_BYTES` is the check byte. A part is valid exactly when its check byte equals the XOR of its `PART_BYTES` data bytes.
- R3: Banks are examined from index 0 upward. A bank with both parts invalid is skipped. The first bank with at least one valid part is reported on `active_bank`.
- R4: When exactly one part of the chosen bank is valid, all its bytes, check byte included, are written over the other part.
- R5: When both parts are valid but any of their bytes differ, part 0 is copied over part 1.
- R6: When both parts are valid and identical, the scanner performs no write.
- R7: After each byte written during restoration, the scanner reads that byte back. A mismatch marks the bank bad and stops its restoration, and the scan goes on with the next bank.
- R8: When every bank is bad, `maint_req` and `scan_ready` go high and `active_bank` is 0.
- R9: Once `scan_ready` is high, it stays high until reset. From then on the scanner makes no memory access, and `active_bank` does not change.
- R10: Read data is taken one cycle after `mem_rd_en`. A read and a write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | ADDR_W | Byte address to the memory |
| mem_rd_en | output | 1 | Read request; data returns the next cycle |
| mem_wr_en | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| scan_ready | output | 1 | Scan and any restoration finished |
| active_bank | output | BANK_W | Index of the bank chosen as live |
| maint_req | output | 1 | No usable bank was found |

## Verification
The hardest case to reach is a failed read-back during restoration. Contents alone cannot cause it, because a healthy memory always returns what was written. The bench memory model therefore has a fault switch that silently drops every write into one chosen bank. That bank is loaded half-written, so the first restored byte reads back wrong. The bench then confirms that exactly one write was issued, that the bank was abandoned, and that the next bank became active.

// File: rtl/bank_scan_pkg.sv
// Shared types for the power-up bank recovery scanner.
// Assumes nothing beyond a byte-wide memory.
package bank_scan_pkg;
    typedef enum logic [2:0] {
        ST_RD_REQ,  // issue a scan read
        ST_RD_CAP,  // capture the scan read data
        ST_DECIDE,  // classify the bank
        ST_WR,      // write one restoration byte
        ST_VRD,     // read that byte back
        ST_VCMP,    // compare the read-back byte
        ST_NEXT,    // move to the next bank
        ST_DONE     // finished, hold
    } scan_st_e;
endpackage

// File: rtl/bank_part_check.sv
// XOR check of one part: byte PART_BYTES holds the check byte.
// Assumes the part is presented as a packed byte vector, byte 0 lowest.
module bank_part_check #(
    parameter int PART_BYTES = 4
) (
    input  logic [PART_BYTES:0][7:0] part_i,
    output logic                     valid_o
);
    logic [7:0] acc;

    // Fold the data bytes and compare the result with the stored check byte.
    always_comb begin
        acc = 8'h00;
        for (int k = 0; k < PART_BYTES; k++) acc = acc ^ part_i[k];
        valid_o = (acc == part_i[PART_BYTES]);
    end
endmodule

// File: rtl/bank_part_buf.sv
// Holds both parts of the bank under scan, one byte written per cycle.
// Assumes idx_i < PART_BYTES+1 whenever we_i is high.
module bank_part_buf #(
    parameter int PART_BYTES = 4,
    parameter int IDX_W      = 3
) (
    input  logic                          clk,
    input  logic                          we_i,
    input  logic                          part_i,
    input  logic [IDX_W-1:0]              idx_i,
    input  logic [7:0]                    din_i,
    output logic [1:0][PART_BYTES:0][7:0] parts_o
);
    logic [1:0][PART_BYTES:0][7:0] store_q;

    // Capture one read byte into its slot.
    always_ff @(posedge clk) begin
        if (we_i) store_q[part_i][idx_i] <= din_i;
    end

    assign parts_o = store_q;
endmodule

// File: rtl/bank_classify.sv
// Classifies a bank from its two buffered parts: per-part validity and equality.
// Assumes the buffer holds a complete read of both parts.
module bank_classify #(
    parameter int PART_BYTES = 4
) (
    input  logic [1:0][PART_BYTES:0][7:0] parts_i,
    output logic                          valid0_o,
    output logic                          valid1_o,
    output logic                          same_o
);
    logic [1:0] valid;

    for (genvar p = 0; p < 2; p++) begin : g_part
        bank_part_check #(.PART_BYTES(PART_BYTES)) u_chk (
            .part_i  (parts_i[p]),
            .valid_o (valid[p])
        );
    end

    assign valid0_o = valid[0];
    assign valid1_o = valid[1];
    assign same_o   = (parts_i[0] == parts_i[1]);
endmodule

// File: rtl/bank_scan_top.sv
// Power-up scanner: finds the first usable bank, restores a half-written one
// with per-byte read-back, and flags maintenance when every bank is bad.
// Assumes a memory with one-cycle read latency and writes visible next cycle.
module bank_scan_top
    import bank_scan_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int PART_BYTES = 4,
    localparam int PART_SZ   = PART_BYTES + 1,
    localparam int BANK_SZ   = 2 * PART_SZ,
    localparam int ADDR_W    = $clog2(NUM_BANKS * BANK_SZ),
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              scan_ready,
    output logic [BANK_W-1:0] active_bank,
    output logic              maint_req
);
    localparam int IDX_W = $clog2(PART_SZ + 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(PART_BYTES);
    localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'(NUM_BANKS - 1);

    scan_st_e          state_q;
    logic [BANK_W-1:0] bank_q;
    logic              part_q;
    logic [IDX_W-1:0]  idx_q;
    logic              src_q;
    logic [BANK_W-1:0] active_q;
    logic              maint_q;

    logic [1:0][PART_BYTES:0][7:0] parts;
    logic valid0, valid1, same;
    logic addr_part;
    int   addr_int;

    bank_part_buf #(.PART_BYTES(PART_BYTES), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .we_i    (state_q == ST_RD_CAP),
        .part_i  (part_q),
        .idx_i   (idx_q),
        .din_i   (mem_rdata),
        .parts_o (parts)
    );

    bank_classify #(.PART_BYTES(PART_BYTES)) u_cls (
        .parts_i  (parts),
        .valid0_o (valid0),
        .valid1_o (valid1),
        .same_o   (same)
    );

    // Form the byte address from bank, part and byte index.
    always_comb begin
        addr_part = (state_q == ST_RD_REQ) ? part_q : ~src_q;
        addr_int  = int'(bank_q) * BANK_SZ + int'(addr_part) * PART_SZ + int'(idx_q);
        mem_addr  = ADDR_W'(addr_int);
    end

    assign mem_rd_en   = (state_q == ST_RD_REQ) || (state_q == ST_VRD);
    assign mem_wr_en   = (state_q == ST_WR);
    assign mem_wdata   = parts[src_q][idx_q];
    assign scan_ready  = (state_q == ST_DONE);
    assign active_bank = active_q;
    assign maint_req   = maint_q;

    // Scan sequencer: read both parts, classify, restore, then settle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RD_REQ;
            bank_q   <= '0;
            part_q   <= 1'b0;
            idx_q    <= '0;
            src_q    <= 1'b0;
            active_q <= '0;
            maint_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_RD_REQ: state_q <= ST_RD_CAP;
                ST_RD_CAP: begin
                    if (idx_q == IDX_LAST) begin
                        idx_q   <= '0;
                        part_q  <= ~part_q;
                        state_q <= part_q ? ST_DECIDE : ST_RD_REQ;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_RD_REQ;
                    end
                end
                ST_DECIDE: begin
                    if (!valid0 && !valid1) begin
                        state_q <= ST_NEXT;
                    end else if (valid0 && valid1 && same) begin
                        active_q <= bank_q;
                        state_q  <= ST_DONE;
                    end else begin
                        src_q   <= valid0 ? 1'b0 : 1'b1;
                        idx_q   <= '0;
                        state_q <= ST_WR;
                    end
                end
                ST_WR:  state_q <= ST_VRD;
                ST_VRD: state_q <= ST_VCMP;
                ST_VCMP: begin
                    if (mem_rdata != parts[src_q][idx_q]) begin
                        state_q <= ST_NEXT;
                    end else if (idx_q == IDX_LAST) begin
                        active_q <= bank_q;
                        state_q  <= ST_DONE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_WR;
                    end
                end
                ST_NEXT: begin
                    if (bank_q == BANK_LAST) begin
                        maint_q  <= 1'b1;
                        active_q <= '0;
                        state_q  <= ST_DONE;
                    end else begin
                        bank_q  <= bank_q + 1'b1;
                        part_q  <= 1'b0;
                        idx_q   <= '0;
                        state_q <= ST_RD_REQ;
                    end
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    // R9
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_ready |=> scan_ready);
    // R9
    quiet_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_ready |-> (!mem_rd_en && !mem_wr_en));
    // R9
    bank_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_ready |=> $stable(active_bank));
    // R8
    maint_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        maint_req |-> scan_ready);
    // R10
    port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
    // R7
    readback_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (mem_rd_en && $stable(mem_addr)));
endmodule

// File: tb/bank_scan_top_tb.sv
// Directed bench: a behavioural byte memory with a write-drop fault per bank.
module bank_scan_top_tb;
    localparam int NB = 4;
    localparam int PB = 4;
    localparam int PS = PB + 1;
    localparam int BS = 2 * PS;
    localparam int DEPTH = NB * BS;
    localparam int AW = $clog2(DEPTH);
    localparam int BW = $clog2(NB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic mem_rd_en, mem_wr_en;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic scan_ready, maint_req;
    logic [BW-1:0] active_bank;

    logic [7:0] mem [DEPTH];
    int stuck_bank = -1;
    int wr_cnt = 0;
    int late_acc = 0;
    int nvec = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    bank_scan_top #(.NUM_BANKS(NB), .PART_BYTES(PB)) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .scan_ready(scan_ready), .active_bank(active_bank), .maint_req(maint_req)
    );

    // Memory model: one-cycle read latency, writes dropped in the stuck bank.
    always @(posedge clk) begin
        if (mem_wr_en && (int'(mem_addr) / BS != stuck_bank)) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    // Access counters, cleared during reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= 0;
            late_acc <= 0;
        end else begin
            if (mem_wr_en) wr_cnt <= wr_cnt + 1;
            if (scan_ready && (mem_wr_en || mem_rd_en)) late_acc <= late_acc + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int base(input int b, input int p);
        return b * BS + p * PS;
    endfunction

    // Load a part from a seed; good=0 corrupts its check byte.
    task automatic put_part(input int b, input int p, input int seed, input bit good);
        logic [7:0] x = 8'h00;
        for (int k = 0; k < PB; k++) begin
            mem[base(b, p) + k] = 8'(seed * 13 + k * 29 + 7);
            x ^= mem[base(b, p) + k];
        end
        mem[base(b, p) + PB] = good ? x : (x ^ 8'h5A);
    endtask

    task automatic fill_all_good();
        for (int b = 0; b < NB; b++) begin
            put_part(b, 0, b + 1, 1'b1);
            put_part(b, 1, b + 1, 1'b1);
        end
    endtask

    function automatic bit parts_equal(input int b);
        for (int k = 0; k < PS; k++)
            if (mem[base(b, 0) + k] !== mem[base(b, 1) + k]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit part_is(input int b, input int p, input int seed);
        logic [7:0] x = 8'h00;
        for (int k = 0; k < PB; k++) begin
            if (mem[base(b, p) + k] !== 8'(seed * 13 + k * 29 + 7)) return 1'b0;
            x ^= mem[base(b, p) + k];
        end
        return mem[base(b, p) + PB] === x;
    endfunction

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Release reset and wait for completion.
    task automatic release_and_wait(input string req);
        int n = 0;
        rst_n = 1'b1;
        while (!scan_ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(scan_ready, req, int'(scan_ready), 1);
    endtask

    task automatic t_intact();
        hold_reset();
        fill_all_good();
        stuck_bank = -1;
        chk(!scan_ready && !maint_req, "R1", int'(scan_ready), 0);
        rst_n = 1'b1;
        chk(mem_rd_en && mem_addr == '0, "R1", int'(mem_addr), 0);
        release_and_wait("R9");
        chk(active_bank == 0, "R6", int'(active_bank), 0);
        chk(wr_cnt == 0, "R6", wr_cnt, 0);
        chk(!maint_req, "R6", int'(maint_req), 0);
        repeat (20) @(negedge clk);
        chk(scan_ready && late_acc == 0, "R9", late_acc, 0);
        chk(active_bank == 0, "R9", int'(active_bank), 0);
    endtask

    task automatic t_skip_then_restore_p0();
        hold_reset();
        fill_all_good();
        stuck_bank = -1;
        put_part(0, 0, 9, 1'b0);
        put_part(0, 1, 9, 1'b0);
        put_part(1, 0, 3, 1'b0);
        put_part(1, 1, 17, 1'b1);
        release_and_wait("R3");
        chk(active_bank == 1, "R3", int'(active_bank), 1);
        chk(part_is(1, 0, 17), "R4", int'(parts_equal(1)), 1);
        chk(wr_cnt == PS, "R4", wr_cnt, PS);
    endtask

    task automatic t_restore_p1();
        hold_reset();
        fill_all_good();
        stuck_bank = -1;
        put_part(0, 0, 21, 1'b1);
        put_part(0, 1, 40, 1'b0);
        release_and_wait("R4");
        chk(active_bank == 0, "R4", int'(active_bank), 0);
        chk(part_is(0, 1, 21) && parts_equal(0), "R4", int'(parts_equal(0)), 1);
    endtask

    task automatic t_both_valid_differ();
        hold_reset();
        fill_all_good();
        stuck_bank = -1;
        put_part(0, 0, 33, 1'b1);
        put_part(0, 1, 34, 1'b1);
        release_and_wait("R5");
        chk(part_is(0, 1, 33), "R5", int'(part_is(0, 1, 33)), 1);
        chk(part_is(0, 0, 33), "R5", int'(part_is(0, 0, 33)), 1);
        chk(active_bank == 0, "R5", int'(active_bank), 0);
    endtask

    task automatic t_readback_fail();
        hold_reset();
        fill_all_good();
        stuck_bank = 0;
        put_part(0, 0, 50, 1'b1);
        put_part(0, 1, 51, 1'b0);
        release_and_wait("R7");
        chk(wr_cnt == 1, "R7", wr_cnt, 1);
        chk(active_bank == 1, "R7", int'(active_bank), 1);
        chk(!maint_req, "R7", int'(maint_req), 0);
        stuck_bank = -1;
    endtask

    task automatic t_all_bad();
        hold_reset();
        stuck_bank = -1;
        for (int b = 0; b < NB; b++) begin
            put_part(b, 0, 60 + b, 1'b0);
            put_part(b, 1, 70 + b, 1'b0);
        end
        release_and_wait("R8");
        chk(maint_req, "R8", int'(maint_req), 1);
        chk(active_bank == 0, "R8", int'(active_bank), 0);
        chk(wr_cnt == 0, "R8", wr_cnt, 0);
        repeat (10) @(negedge clk);
        chk(scan_ready && maint_req && late_acc == 0, "R9", late_acc, 0);
    endtask

    // Watchdog: a hang is a failed check and still prints the summary.
    initial begin
        #(5.0 * 200000);
        nvec++;
        nfail++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) mem[a] = 8'h00;
        t_intact();                // R1 R6 R9 R10
        t_skip_then_restore_p0();  // R2 R3 R4
        t_restore_p1();            // R4
        t_both_valid_differ();     // R5
        t_readback_fail();         // R7
        t_all_bad();               // R8
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule